// File: doc/BRIEF.md
# BCH-8 Sector Error Corrector

This block finishes the correction of one 512-byte sector after a hardware BCH decoder has run. The decoder protects each sector with 13 parity bytes and can locate up to eight bit errors. It hands this block three 32-bit location words and a 32-bit status word. The status word holds a code-ready flag, a 4-bit error count and the top eight bits of the packed location field. The block unpacks eight 13-bit bit indices from these words. It adjusts each index by XOR with 3. It then inverts each addressed bit in the sector buffer, using a byte-wide read-modify-write memory port. At the end it reports how many bits it flipped, or that the sector cannot be corrected.

A request is offered with `req_valid` and the four words, and is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. A requester that sees it low must hold `req_valid` and all four words unchanged until the handshake cycle. The memory port and the result pins are plain. A read returns data the cycle after `mem_rd_en`. `done` is a one-cycle pulse.

Top module: `bch_err_fixer`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request is taken only on a cycle with `req_valid` and `req_ready` both high, and `req_ready` stays low from the cycle after a taken request with code-ready set until the cycle after `done`.
- R2: A taken request whose code-ready flag (status bit 15) is clear is dropped. It causes no memory access and no `done`, and it leaves `req_ready` high.
- R3: The error count is status bits 13:10. A count above 8 gives a `done` pulse with `uncorrectable` = 1 and `corr_count` = 0, and causes no memory access.
- R4: A count of zero gives a `done` pulse on the cycle after the request is taken, with `corr_count` = 0 and `uncorrectable` = 0, and causes no memory access.
- R5: Location k (k = 0..7) is bits 13k+12 down to 13k of the 104-bit value {status[23:16], word3, word2, word1}. So location 2 spans word1[31:26] (low) and word2[6:0], location 4 spans word2[31:20] and word3[0], and location 7 spans word3[31:27] and status[23:16].
- R6: Each location is XORed with 3 to give an index. For an index below 4096, bit (index & 7) of byte (index >> 3) is inverted. A location that appears twice flips its bit twice.
- R7: An index of 4096 or more is skipped without any memory access, but it still uses up one unit of the error count.
- R8: Only locations 0 to count-1 are used, in ascending order. Each applied flip is one read with `mem_rd_en`, followed on the next cycle by one write with `mem_wr_en` to the same address.
- R9: `corr_count` equals the number of flips applied. `done` is a single-cycle pulse that follows the last write, and `corr_count` and `uncorrectable` hold their values until the next request is taken.
- R10: After reset `req_ready` = 1, and `done`, `mem_rd_en`, `mem_wr_en`, `corr_count` and `uncorrectable` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| sts_word | input | 32 | Decoder status: code-ready bit 15, count 13:10, location bits 23:16 |
| loc_word1 | input | 32 | Packed location bits 31:0 |
| loc_word2 | input | 32 | Packed location bits 63:32 |
| loc_word3 | input | 32 | Packed location bits 95:64 |
| mem_rd_en | output | 1 | Sector buffer read strobe |
| mem_wr_en | output | 1 | Sector buffer write strobe |
| mem_addr | output | 9 | Byte address in the sector |
| mem_wdata | output | 8 | Corrected byte |
| mem_rdata | input | 8 | Read byte, valid the cycle after `mem_rd_en` |
| done | output | 1 | One-cycle completion pulse |
| corr_count | output | 4 | Number of flips applied |
| uncorrectable | output | 1 | Error count exceeded 8 |

## Verification
The bench places a distinct bit at every location slot, so that a slip in any location that crosses a word boundary lands on the wrong byte of the sector image. It targets indices one below and at 4096, all-ones raw values, and mixes of valid and out-of-range slots. A design that lets a skipped slot not count against the error count would flip bits past the count. A design that forgets the XOR with 3 would hit the neighbouring bit. It also covers a count smaller than the number of filled slots, the same location given twice (a design that merges them would leave the sector changed), counts 0, 9 and 15 (a design that touches memory there would corrupt the image), and a request with code-ready clear, which must leave no trace.

// File: rtl/bch_fix_pkg.sv
package bch_fix_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } seq_st_t;

  localparam int unsigned IDX_ADJUST = 3;
endpackage

// File: rtl/bch_req_latch.sv
module bch_req_latch #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned TAIL_W  = 8,
  localparam int unsigned PACK_W = 3 * WORD_W + TAIL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TAIL_W-1:0] tail_bits,
  input  logic [WORD_W-1:0] word1,
  input  logic [WORD_W-1:0] word2,
  input  logic [WORD_W-1:0] word3,
  output logic [PACK_W-1:0] packed_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      packed_q <= '0;
    end else if (load) begin
      packed_q <= {tail_bits, word3, word2, word1};
    end
  end
endmodule

// File: rtl/bch_loc_unpack.sv
module bch_loc_unpack #(
  parameter int unsigned N_LOC   = 8,
  parameter int unsigned LOC_W   = 13,
  parameter int unsigned ADJUST  = 3,
  parameter int unsigned LIMIT   = 4096,
  localparam int unsigned PACK_W = N_LOC * LOC_W
) (
  input  logic [PACK_W-1:0]           packed_locs,
  output logic [N_LOC-1:0][LOC_W-1:0] loc_idx,
  output logic [N_LOC-1:0]            loc_ok
);
  localparam logic [LOC_W-1:0] ADJ_V = LOC_W'(ADJUST);
  localparam logic [LOC_W-1:0] LIM_V = LOC_W'(LIMIT);

  for (genvar k = 0; k < N_LOC; k++) begin : g_loc
    logic [LOC_W-1:0] raw;
    assign raw        = packed_locs[k*LOC_W +: LOC_W];
    assign loc_idx[k] = raw ^ ADJ_V;
    assign loc_ok[k]  = (loc_idx[k] < LIM_V);
  end
endmodule

// File: rtl/bch_flip_seq.sv
module bch_flip_seq
  import bch_fix_pkg::*;
#(
  parameter int unsigned N_LOC  = 8,
  parameter int unsigned LOC_W  = 13,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [CNT_W-1:0]            start_cnt,
  input  logic [N_LOC-1:0][LOC_W-1:0] loc_idx,
  input  logic [N_LOC-1:0]            loc_ok,
  output logic                        busy,
  output logic                        mem_rd_en,
  output logic                        mem_wr_en,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [BYTE_W-1:0]           mem_wdata,
  input  logic [BYTE_W-1:0]           mem_rdata,
  output logic                        done,
  output logic [CNT_W-1:0]            res_count,
  output logic                        res_unc
);
  localparam int unsigned SEL_W     = $clog2(N_LOC);
  localparam int unsigned BIT_SEL_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(N_LOC);

  seq_st_t          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ptr_q;
  logic [CNT_W-1:0] flips_q;
  logic             unc_q;

  logic [SEL_W-1:0] sel;
  logic [LOC_W-1:0] cur;
  logic             cur_ok;
  logic             at_end;

  assign sel    = ptr_q[SEL_W-1:0];
  assign cur    = loc_idx[sel];
  assign cur_ok = loc_ok[sel];
  assign at_end = (ptr_q == cnt_q);

  logic unused_hi;
  assign unused_hi = ^cur[LOC_W-1:BIT_SEL_W+ADDR_W] ^ ^ptr_q[CNT_W-1:SEL_W];

  always_comb begin
    mem_rd_en = 1'b0;
    mem_wr_en = 1'b0;
    case (st_q)
      ST_LOOK: mem_rd_en = !at_end && cur_ok;
      ST_WR:   mem_wr_en = 1'b1;
      default: ;
    endcase
  end

  assign mem_addr  = cur[BIT_SEL_W +: ADDR_W];
  assign mem_wdata = mem_rdata ^ (BYTE_W'(1) << cur[BIT_SEL_W-1:0]);
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_FIN);
  assign res_count = flips_q;
  assign res_unc   = unc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      ptr_q   <= '0;
      flips_q <= '0;
      unc_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            cnt_q   <= start_cnt;
            ptr_q   <= '0;
            flips_q <= '0;
            unc_q   <= (start_cnt > MAX_CNT);
            if (start_cnt == '0 || start_cnt > MAX_CNT) begin
              st_q <= ST_FIN;
            end else begin
              st_q <= ST_LOOK;
            end
          end
        end
        ST_LOOK: begin
          if (at_end) begin
            st_q <= ST_FIN;
          end else if (cur_ok) begin
            st_q <= ST_WR;
          end else begin
            ptr_q <= ptr_q + 1'b1;
          end
        end
        ST_WR: begin
          flips_q <= flips_q + 1'b1;
          ptr_q   <= ptr_q + 1'b1;
          st_q    <= ST_LOOK;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bch_err_fixer.sv
module bch_err_fixer #(
  parameter int unsigned SECTOR_BYTES = 512,
  parameter int unsigned N_LOC        = 8,
  parameter int unsigned LOC_W        = 13,
  parameter int unsigned CNT_W        = 4,
  parameter int unsigned WORD_W       = 32,
  parameter int unsigned BYTE_W       = 8,
  parameter int unsigned RDY_BIT      = 15,
  parameter int unsigned CNT_LSB      = 10,
  parameter int unsigned TAIL_LSB     = 16,
  localparam int unsigned ADDR_W      = $clog2(SECTOR_BYTES),
  localparam int unsigned PACK_W      = N_LOC * LOC_W,
  localparam int unsigned TAIL_W      = PACK_W - 3 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] sts_word,
  input  logic [WORD_W-1:0] loc_word1,
  input  logic [WORD_W-1:0] loc_word2,
  input  logic [WORD_W-1:0] loc_word3,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              done,
  output logic [CNT_W-1:0]  corr_count,
  output logic              uncorrectable
);
  import bch_fix_pkg::*;

  logic                        busy;
  logic                        start;
  logic [PACK_W-1:0]           packed_q;
  logic [N_LOC-1:0][LOC_W-1:0] loc_idx;
  logic [N_LOC-1:0]            loc_ok;

  assign req_ready = !busy;
  assign start     = req_valid && req_ready && sts_word[RDY_BIT];

  logic unused_sts;
  assign unused_sts = ^sts_word[CNT_LSB-1:0] ^ sts_word[RDY_BIT-1]
                    ^ ^sts_word[WORD_W-1:TAIL_LSB+TAIL_W];

  bch_req_latch #(
    .WORD_W(WORD_W),
    .TAIL_W(TAIL_W)
  ) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .tail_bits(sts_word[TAIL_LSB +: TAIL_W]),
    .word1    (loc_word1),
    .word2    (loc_word2),
    .word3    (loc_word3),
    .packed_q (packed_q)
  );

  bch_loc_unpack #(
    .N_LOC (N_LOC),
    .LOC_W (LOC_W),
    .ADJUST(IDX_ADJUST),
    .LIMIT (SECTOR_BYTES * BYTE_W)
  ) u_unpack (
    .packed_locs(packed_q),
    .loc_idx    (loc_idx),
    .loc_ok     (loc_ok)
  );

  bch_flip_seq #(
    .N_LOC (N_LOC),
    .LOC_W (LOC_W),
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W),
    .BYTE_W(BYTE_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_cnt(sts_word[CNT_LSB +: CNT_W]),
    .loc_idx  (loc_idx),
    .loc_ok   (loc_ok),
    .busy     (busy),
    .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .done     (done),
    .res_count(corr_count),
    .res_unc  (uncorrectable)
  );
endmodule

// File: rtl/bch_err_fixer_chk.sv
module bch_err_fixer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] sts_word,
  input logic [31:0] loc_word1,
  input logic [31:0] loc_word2,
  input logic [31:0] loc_word3,
  input logic        mem_rd_en,
  input logic        mem_wr_en,
  input logic [8:0]  mem_addr,
  input logic [7:0]  mem_wdata,
  input logic [7:0]  mem_rdata,
  input logic        done,
  input logic [3:0]  corr_count,
  input logic        uncorrectable
);
  logic taken;
  assign taken = req_valid && req_ready;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd_en && !mem_wr_en));

  assert_drop_unready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !sts_word[15]) |=> (req_ready && !done));

  assert_uncorrectable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && sts_word[15] && sts_word[13:10] > 4'd8)
      |=> (done && uncorrectable && corr_count == 4'd0));

  assert_zero_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && sts_word[15] && sts_word[13:10] == 4'd0)
      |=> (done && !uncorrectable && corr_count == 4'd0));

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_en, mem_wr_en, done}));

  assert_read_then_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (mem_wr_en && $stable(mem_addr)));

  assert_write_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (corr_count <= 4'd8));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !taken && !$past(taken))
      |-> ($stable(corr_count) && $stable(uncorrectable)));
endmodule

bind bch_err_fixer bch_err_fixer_chk u_chk (.*);

// File: tb/tb_bch_err_fixer.sv
`timescale 1ns/1ps
module tb_bch_err_fixer;
  typedef struct packed {
    logic [3:0]       cnt;
    logic [7:0][12:0] raw;
    logic [3:0]       exp_n;
    logic             exp_unc;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  {13'h0, 13'h0, 13'h0, 13'h0, 13'h0, 13'h0, 13'h0, 13'h0003}, 4'd1, 1'b0},
    '{4'd8,  {13'h0FFC, 13'h0F00, 13'h0DEF, 13'h0ABC, 13'h0789, 13'h0456, 13'h0123, 13'h0010}, 4'd8, 1'b0},
    '{4'd3,  {13'h0, 13'h0, 13'h0, 13'h0, 13'h0, 13'h0100, 13'h1003, 13'h1FFF}, 4'd1, 1'b0},
    '{4'd2,  {13'h0, 13'h0, 13'h0, 13'h0, 13'h0, 13'h0, 13'h0055, 13'h0055}, 4'd2, 1'b0},
    '{4'd4,  {13'h0303, 13'h0302, 13'h0301, 13'h0300, 13'h0203, 13'h0202, 13'h0201, 13'h0200}, 4'd4, 1'b0},
    '{4'd0,  {13'h0040, 13'h0041, 13'h0042, 13'h0043, 13'h0044, 13'h0045, 13'h0046, 13'h0047}, 4'd0, 1'b0},
    '{4'd9,  {13'h0020, 13'h0021, 13'h0022, 13'h0023, 13'h0024, 13'h0025, 13'h0026, 13'h0027}, 4'd0, 1'b1},
    '{4'd15, {13'h0030, 13'h0031, 13'h0032, 13'h0033, 13'h0034, 13'h0035, 13'h0036, 13'h0037}, 4'd0, 1'b1},
    '{4'd8,  {13'h0001, 13'h1000, 13'h0FFF, 13'h1FFF, 13'h0555, 13'h1555, 13'h0AAA, 13'h1AAA}, 4'd4, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] sts_word = '0;
  logic [31:0] loc_word1 = '0;
  logic [31:0] loc_word2 = '0;
  logic [31:0] loc_word3 = '0;
  logic        mem_rd_en, mem_wr_en;
  logic [8:0]  mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        done;
  logic [3:0]  corr_count;
  logic        uncorrectable;

  always #2 clk = ~clk;

  bch_err_fixer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .sts_word(sts_word), .loc_word1(loc_word1), .loc_word2(loc_word2),
    .loc_word3(loc_word3), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .corr_count(corr_count), .uncorrectable(uncorrectable)
  );

  logic [7:0] mem [512];
  logic [7:0] ref_mem [512];
  int rd_n = 0;
  int wr_n = 0;
  int checks = 0;
  int errors = 0;

  initial begin
    mem_rdata = '0;
    for (int i = 0; i < 512; i++) begin
      mem[i]     = 8'((i * 7 + 3) & 255);
      ref_mem[i] = 8'((i * 7 + 3) & 255);
    end
  end

  always @(posedge clk) begin
    if (mem_wr_en) begin
      mem[mem_addr] <= mem_wdata;
      wr_n <= wr_n + 1;
    end
    if (mem_rd_en) begin
      mem_rdata <= mem[mem_addr];
      rd_n <= rd_n + 1;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic logic [127:0] pack(input vec_t v, input bit rdy);
    logic [103:0] b;
    for (int k = 0; k < 8; k++) b[k*13 +: 13] = v.raw[k];
    return {8'h00, b[103:96], rdy, 1'b0, v.cnt, 10'h000, b[95:0]};
  endfunction

  function automatic void apply_ref(input vec_t v);
    if (v.cnt <= 4'd8) begin
      for (int k = 0; k < 8; k++) begin
        if (k < int'(v.cnt)) begin
          logic [12:0] idx;
          idx = v.raw[k] ^ 13'd3;
          if (idx < 13'd4096) ref_mem[idx[11:3]] ^= 8'(1 << idx[2:0]);
        end
      end
    end
  endfunction

  int mem_bad;
  task automatic compare_mem(input string what);
    mem_bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== ref_mem[i]) mem_bad++;
    check(mem_bad == 0, what, mem_bad, 0);
  endtask

  task automatic send(input logic [127:0] w);
    @(negedge clk);
    {sts_word, loc_word3, loc_word2, loc_word1} = w;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  bit seen;
  logic [3:0] got_n;
  logic got_unc;
  task automatic wait_done();
    seen = 1'b0;
    for (int t = 0; t < 100 && !seen; t++) begin
      if (done) begin
        seen = 1'b1;
        got_n = corr_count;
        got_unc = uncorrectable;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int rd0, wr0;
  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(req_ready == 1'b1, "R10 req_ready after reset", int'(req_ready), 1);
    check(done == 1'b0, "R10 done after reset", int'(done), 0);
    check(corr_count == 4'd0 && uncorrectable == 1'b0, "R10 results after reset",
          int'(corr_count), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(rd_n == 0 && wr_n == 0, "R10 no access after reset", rd_n + wr_n, 0);

    for (int v = 0; v < NV; v++) begin
      rd0 = rd_n;
      wr0 = wr_n;
      apply_ref(VECS[v]);
      send(pack(VECS[v], 1'b1));
      wait_done();
      check(seen, $sformatf("R9 done seen vec %0d", v), int'(seen), 1);
      check(got_n == VECS[v].exp_n, $sformatf("R7 R9 corr_count vec %0d", v),
            int'(got_n), int'(VECS[v].exp_n));
      check(got_unc == VECS[v].exp_unc, $sformatf("R3 uncorrectable vec %0d", v),
            int'(got_unc), int'(VECS[v].exp_unc));
      check(wr_n - wr0 == int'(VECS[v].exp_n), $sformatf("R4 R8 write count vec %0d", v),
            wr_n - wr0, int'(VECS[v].exp_n));
      check(rd_n - rd0 == int'(VECS[v].exp_n), $sformatf("R7 R8 read count vec %0d", v),
            rd_n - rd0, int'(VECS[v].exp_n));
      compare_mem($sformatf("R5 R6 sector image vec %0d", v));
      @(negedge clk);
    end

    // R2: code-ready clear must be dropped
    rd0 = rd_n;
    wr0 = wr_n;
    send(pack(VECS[0], 1'b0));
    seen = 1'b0;
    for (int t = 0; t < 20; t++) begin
      if (done) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R2 no done when code-ready clear", int'(seen), 0);
    check(rd_n == rd0 && wr_n == wr0, "R2 no access when code-ready clear",
          (rd_n - rd0) + (wr_n - wr0), 0);
    check(req_ready == 1'b1, "R2 ready stays high", int'(req_ready), 1);
    compare_mem("R2 sector untouched");

    // R1: busy back-pressure, R9: result hold
    apply_ref(VECS[1]);
    @(negedge clk);
    {sts_word, loc_word3, loc_word2, loc_word1} = pack(VECS[1], 1'b1);
    req_valid = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b0, "R1 ready low while busy", int'(req_ready), 0);
    wait_done();
    req_valid = 1'b0;
    check(seen && got_n == 4'd8, "R1 job under held valid", int'(got_n), 8);
    compare_mem("R1 sector after held job");
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready back after done", int'(req_ready), 1);
    check(corr_count == 4'd8 && !uncorrectable, "R9 results held", int'(corr_count), 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule